// File: doc/BRIEF.md
# Transceiver Operating Mode Controller

This block is the mode state machine for a single-wire bus transceiver. It keeps the transceiver in one of three modes (sleep, standby and normal) and drives the control lines that follow from the mode. These are the regulator-inhibit enable, the receive-output mode, the transmit-path enable, and a strong pull-down request on the transmit pin that reports the wake source. The block takes an asynchronous enable level, which it synchronises itself. It also takes single-cycle wake pulses from a separate wake detector, one for a bus wake and one for a local wake. Thresholds, wake filtering and the analog driver lie outside it.

The block can reach normal mode only through standby, after a wake. In standby the receive output is forced low as a wake request. If a local-input pulse caused the wake, the transmit pin is also pulled down strongly to identify the source. A mode change driven by enable waits until the synchronised enable has held its new level for `MODE_DLY_CYC` consecutive cycles. This applies to standby to normal and to normal to sleep. Until then the outputs keep the old mode's values. Software should treat the receive output as indeterminate during that window. A floating enable, held low by the external pull-down, keeps the block in low-power mode.

There is no data stream at the block's edge. Every pin is a plain level or a single-cycle pulse, so there is no valid/ready handshake and no back-pressure.

Top module: `xmc_mode_ctrl`

## Requirements
- R1: After reset the status output `mode_o` reads sleep. The status encoding is 00 sleep, 01 standby and 10 normal. In the same state `inh_en_o`, `tx_path_en_o` and `tx_src_pd_o` are 0 and `rx_mode_o` is release. The receive encoding is 00 release high, 01 mirror bus and 10 force low.
- R2: In sleep, a bus-wake or local-wake pulse sampled at a clock edge gives standby after that same edge. A high enable level also wakes the block. Through the two-flop synchroniser, standby appears at the third edge after enable rises.
- R3: In standby `inh_en_o` is 1, `rx_mode_o` is force low (10), `tx_path_en_o` is 0 and `mode_o` is 01.
- R4: `tx_src_pd_o` is 1 only in standby, and only when a local-wake pulse arrived in sleep or in the current standby stay. A pulse on both wake inputs in the same cycle counts as local. A wake from the bus or from enable leaves it 0. The flag clears when standby is left.
- R5: Standby moves to normal at the edge where the synchronised enable has been high for `MODE_DLY_CYC` consecutive cycles. Any low sample in between restarts the count.
- R6: In normal `inh_en_o` is 1, `rx_mode_o` is mirror (01), `tx_path_en_o` is 1, `tx_src_pd_o` is 0 and `mode_o` is 10.
- R7: Normal moves to sleep at the edge where the synchronised enable has been low for `MODE_DLY_CYC` consecutive cycles. A high sample in between cancels the move.
- R8: Wake pulses in normal change no output. Wake pulses in standby do not change the mode.
- R9: In sleep `inh_en_o` and `tx_path_en_o` are 0 and `rx_mode_o` is release. The status never goes from sleep straight to normal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_async_i | input | 1 | Mode enable level, asynchronous |
| wake_bus_i | input | 1 | One-cycle pulse: wake detected on the bus |
| wake_local_i | input | 1 | One-cycle pulse: wake detected on the local input |
| inh_en_o | output | 1 | Regulator-inhibit switch enable |
| rx_mode_o | output | 2 | Receive output mode: 00 release, 01 mirror, 10 low |
| tx_path_en_o | output | 1 | Transmit data may drive the bus |
| tx_src_pd_o | output | 1 | Strong pull-down on transmit pin (local wake source) |
| mode_o | output | 2 | Mode status: 00 sleep, 01 standby, 10 normal |

## Verification
The bench runs `MODE_DLY_CYC` at a small value. It samples exactly one edge before and one edge on the expected mode change, so a counter that is off by one cycle, in either direction, shows up as a mode change in the wrong cycle. It pulses the enable low, or high, for fewer than the dwell cycles. A counter that does not restart would then let the block drop into sleep, or jump to normal, from that short glitch. The bench also wakes the block from enable, from the bus and from both wake inputs at once. A wrong source flag would assert the strong pull-down after a bus or enable wake, or miss it after a local one. Wake pulses in normal check that the block never falls back to standby.

// File: rtl/xmc_pkg.sv
package xmc_pkg;
  typedef enum logic [1:0] {
    MODE_SLEEP   = 2'b00,
    MODE_STANDBY = 2'b01,
    MODE_NORMAL  = 2'b10
  } mode_e;

  typedef enum logic [1:0] {
    RXM_RELEASE = 2'b00,
    RXM_MIRROR  = 2'b01,
    RXM_LOW     = 2'b10
  } rxm_e;
endpackage

// File: rtl/xmc_sync.sv
module xmc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b0;
        else if (g == 0) chain[g] <= d_i;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/xmc_dwell.sv
module xmc_dwell #(
  parameter int DLY = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  output logic done_o
);
  localparam int CW = (DLY < 2) ? 1 : $clog2(DLY);
  localparam logic [CW-1:0] LAST = CW'(DLY - 1);

  logic [CW-1:0] cnt;

  assign done_o = arm_i && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (!arm_i || done_o) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/xmc_fsm.sv
module xmc_fsm
  import xmc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en_s_i,
  input  logic  wake_bus_i,
  input  logic  wake_local_i,
  input  logic  dwell_done_i,
  output logic  dwell_arm_o,
  output mode_e mode_o,
  output logic  src_local_o
);
  mode_e mode_q, mode_d;
  logic  src_q, src_d;

  always_comb begin
    mode_d = mode_q;
    src_d  = 1'b0;
    unique case (mode_q)
      MODE_SLEEP: begin
        if (wake_bus_i || wake_local_i || en_s_i) begin
          mode_d = MODE_STANDBY;
          src_d  = wake_local_i;
        end
      end
      MODE_STANDBY: begin
        if (dwell_done_i) mode_d = MODE_NORMAL;
        else src_d = src_q || wake_local_i;
      end
      MODE_NORMAL: begin
        if (dwell_done_i) mode_d = MODE_SLEEP;
      end
      default: mode_d = MODE_SLEEP;
    endcase
  end

  always_comb begin
    unique case (mode_q)
      MODE_STANDBY: dwell_arm_o = en_s_i;
      MODE_NORMAL:  dwell_arm_o = !en_s_i;
      default:      dwell_arm_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_SLEEP;
      src_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      src_q  <= src_d;
    end
  end

  assign mode_o      = mode_q;
  assign src_local_o = src_q;
endmodule

// File: rtl/xmc_outdec.sv
module xmc_outdec
  import xmc_pkg::*;
(
  input  mode_e      mode_i,
  input  logic       src_local_i,
  output logic       inh_en_o,
  output logic [1:0] rx_mode_o,
  output logic       tx_path_en_o,
  output logic       tx_src_pd_o
);
  always_comb begin
    inh_en_o     = 1'b0;
    rx_mode_o    = RXM_RELEASE;
    tx_path_en_o = 1'b0;
    tx_src_pd_o  = 1'b0;
    unique case (mode_i)
      MODE_STANDBY: begin
        inh_en_o    = 1'b1;
        rx_mode_o   = RXM_LOW;
        tx_src_pd_o = src_local_i;
      end
      MODE_NORMAL: begin
        inh_en_o     = 1'b1;
        rx_mode_o    = RXM_MIRROR;
        tx_path_en_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/xmc_mode_ctrl.sv
module xmc_mode_ctrl
  import xmc_pkg::*;
#(
  parameter int MODE_DLY_CYC = 250,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_async_i,
  input  logic       wake_bus_i,
  input  logic       wake_local_i,
  output logic       inh_en_o,
  output logic [1:0] rx_mode_o,
  output logic       tx_path_en_o,
  output logic       tx_src_pd_o,
  output logic [1:0] mode_o
);
  logic  en_s;
  logic  arm, done, src_local;
  mode_e mode;

  xmc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(en_async_i), .q_o(en_s)
  );

  xmc_dwell #(.DLY(MODE_DLY_CYC)) u_dwell (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .done_o(done)
  );

  xmc_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .en_s_i(en_s),
    .wake_bus_i(wake_bus_i), .wake_local_i(wake_local_i),
    .dwell_done_i(done), .dwell_arm_o(arm),
    .mode_o(mode), .src_local_o(src_local)
  );

  xmc_outdec u_dec (
    .mode_i(mode), .src_local_i(src_local),
    .inh_en_o(inh_en_o), .rx_mode_o(rx_mode_o),
    .tx_path_en_o(tx_path_en_o), .tx_src_pd_o(tx_src_pd_o)
  );

  assign mode_o = mode;
endmodule

// File: rtl/xmc_mode_ctrl_chk.sv
module xmc_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wake_bus_i,
  input logic       wake_local_i,
  input logic       inh_en_o,
  input logic [1:0] rx_mode_o,
  input logic       tx_path_en_o,
  input logic       tx_src_pd_o,
  input logic [1:0] mode_o
);
  // R2: a wake pulse in sleep gives standby at the next edge
  p_wake_from_sleep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b00 && (wake_bus_i || wake_local_i)) |=> (mode_o == 2'b01));

  // R3: standby drives the wake-request pattern
  p_standby_pins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b01) |-> (inh_en_o && rx_mode_o == 2'b10 && !tx_path_en_o));

  // R4: source pull-down only while in standby
  p_pd_in_standby_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_src_pd_o |-> (mode_o == 2'b01));

  // R6: normal opens both paths
  p_normal_pins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b10) |-> (inh_en_o && tx_path_en_o && rx_mode_o == 2'b01));

  // R8: wake pulses never pull normal back to standby
  p_normal_no_standby_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b10) |=> (mode_o != 2'b01));

  // R9: no direct jump from sleep to normal
  p_no_skip_standby_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b00) |=> (mode_o != 2'b10));

  // R9: sleep keeps regulator and transmit path off
  p_sleep_pins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'b00) |-> (!inh_en_o && !tx_path_en_o && rx_mode_o == 2'b00));
endmodule

bind xmc_mode_ctrl xmc_mode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wake_bus_i(wake_bus_i), .wake_local_i(wake_local_i),
  .inh_en_o(inh_en_o), .rx_mode_o(rx_mode_o), .tx_path_en_o(tx_path_en_o),
  .tx_src_pd_o(tx_src_pd_o), .mode_o(mode_o)
);

// File: tb/xmc_mode_ctrl_tb.sv
module xmc_mode_ctrl_tb_top;
  localparam int D = 6;
  localparam logic [1:0] SLP = 2'b00, STB = 2'b01, NRM = 2'b10;
  localparam logic [1:0] RREL = 2'b00, RMIR = 2'b01, RLOW = 2'b10;

  // {req[3:0], en, bus, loc, n[7:0], mode[1:0], rx[1:0], inh, tx, pd}
  localparam int NV = 13;
  localparam logic [21:0] VEC [NV] = '{
    {4'd2, 1'b0, 1'b1, 1'b0, 8'd1,     STB, RLOW, 1'b1, 1'b0, 1'b0}, // R2 R3 bus wake
    {4'd3, 1'b0, 1'b0, 1'b0, 8'd20,    STB, RLOW, 1'b1, 1'b0, 1'b0}, // R3 holds
    {4'd5, 1'b1, 1'b0, 1'b0, 8'(D+1),  STB, RLOW, 1'b1, 1'b0, 1'b0}, // R5 one edge early
    {4'd5, 1'b1, 1'b0, 1'b0, 8'd1,     NRM, RMIR, 1'b1, 1'b1, 1'b0}, // R5 R6 on time
    {4'd8, 1'b1, 1'b0, 1'b1, 8'd3,     NRM, RMIR, 1'b1, 1'b1, 1'b0}, // R8 ignored
    {4'd7, 1'b0, 1'b0, 1'b0, 8'(D+1),  NRM, RMIR, 1'b1, 1'b1, 1'b0}, // R7 one edge early
    {4'd9, 1'b0, 1'b0, 1'b0, 8'd1,     SLP, RREL, 1'b0, 1'b0, 1'b0}, // R7 R9 on time
    {4'd4, 1'b0, 1'b0, 1'b1, 8'd1,     STB, RLOW, 1'b1, 1'b0, 1'b1}, // R4 local wake
    {4'd8, 1'b0, 1'b1, 1'b0, 8'd1,     STB, RLOW, 1'b1, 1'b0, 1'b1}, // R8 R4 kept
    {4'd4, 1'b1, 1'b0, 1'b0, 8'(D+2),  NRM, RMIR, 1'b1, 1'b1, 1'b0}, // R4 cleared
    {4'd7, 1'b0, 1'b0, 1'b0, 8'(D+2),  SLP, RREL, 1'b0, 1'b0, 1'b0}, // R7
    {4'd2, 1'b1, 1'b0, 1'b0, 8'd3,     STB, RLOW, 1'b1, 1'b0, 1'b0}, // R2 enable wake, R4 no pd
    {4'd5, 1'b1, 1'b0, 1'b0, 8'(D),    NRM, RMIR, 1'b1, 1'b1, 1'b0}  // R5
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, wb = 1'b0, wl = 1'b0;
  logic inh, tx, pd;
  logic [1:0] rx, mode;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  xmc_mode_ctrl #(.MODE_DLY_CYC(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .en_async_i(en), .wake_bus_i(wb), .wake_local_i(wl),
    .inh_en_o(inh), .rx_mode_o(rx), .tx_path_en_o(tx), .tx_src_pd_o(pd), .mode_o(mode)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic [1:0] m, input logic [1:0] r,
                         input logic i, input logic t, input logic p);
    chk(req, "mode", int'(mode), int'(m));
    chk(req, "rx",   int'(rx),   int'(r));
    chk(req, "inh",  int'(inh),  int'(i));
    chk(req, "tx",   int'(tx),   int'(t));
    chk(req, "pd",   int'(pd),   int'(p));
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk_all("R1", SLP, RREL, 1'b0, 1'b0, 1'b0);   // R1 in reset
    rst_n = 1'b1;
    edges(3);
    chk_all("R1", SLP, RREL, 1'b0, 1'b0, 1'b0);   // R1 after release, R9 idle

    for (int v = 0; v < NV; v++) begin
      logic [21:0] e;
      e  = VEC[v];
      en = e[17]; wb = e[16]; wl = e[15];
      @(posedge clk);
      @(negedge clk);
      wb = 1'b0; wl = 1'b0;
      if (e[14:7] > 1) edges(int'(e[14:7]) - 1);
      chk_all($sformatf("R%0d", e[21:18]), e[6:5], e[4:3], e[2], e[1], e[0]);
    end

    // R7: short low glitch on enable in normal does not drop to sleep
    en = 1'b0; edges(4);
    en = 1'b1; edges(D + 4);
    chk("R7", "mode after glitch", int'(mode), int'(NRM));

    // go to sleep, then bus wake; R5: short high glitch in standby
    en = 1'b0; edges(D + 3);
    chk("R7", "mode", int'(mode), int'(SLP));
    wb = 1'b1; @(posedge clk); @(negedge clk); wb = 1'b0;
    en = 1'b1; edges(4);
    en = 1'b0; edges(D + 4);
    chk("R5", "mode after glitch", int'(mode), int'(STB));

    // R4: both wake pulses together in sleep count as local
    rst_n = 1'b0; edges(1);
    chk_all("R1", SLP, RREL, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1; edges(1);
    wb = 1'b1; wl = 1'b1; @(posedge clk); @(negedge clk); wb = 1'b0; wl = 1'b0;
    chk_all("R4", STB, RLOW, 1'b1, 1'b0, 1'b1);

    // R8: standby stays standby under repeated wake pulses
    wb = 1'b1; edges(3); wb = 1'b0;
    chk("R8", "mode", int'(mode), int'(STB));

    // R1: reset from normal
    en = 1'b1; edges(D + 3);
    chk("R6", "mode", int'(mode), int'(NRM));
    rst_n = 1'b0; en = 1'b0; edges(1);
    chk_all("R1", SLP, RREL, 1'b0, 1'b0, 1'b0);

    done = 1'b1;
    finish_run();
  end
endmodule